// File: doc/BRIEF.md
# SPI Word/Byte Data FIFO

This block holds the transmit and receive bytes between a register bus and an SPI shift engine. On the send side, software loads data one 32-bit word at a time (four bytes) or one byte at a time. The shift engine drains the bytes one by one through a valid/ready pair. On the receive side, the shift engine delivers bytes one at a time. Software takes them out four at a time as a word, or one at a time as a byte. Internally, both directions are byte queues. Any access of either width therefore keeps byte order intact.

A four-bit sticky status vector reports four events:
- the transmit queue has drained;
- a full word is ready to read;
- at least one byte is ready to read;
- a transmit write was lost because the queue was full.

Software clears the bits by writing ones to a clear strobe. A soft-reset input empties both queues in one cycle, for example to abandon a transfer.

Top module: `spi_data_fifo`

## Requirements
- R1: A word write (`tx_word_we_i`) queues the four bytes of `tx_wdata_i` for the shift engine in this order: bits 7:0, then 15:8, then 23:16, then 31:24. The engine takes one byte per cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R2: A byte write (`tx_byte_we_i`, used only when no word write is asserted) queues only `tx_wdata_i[7:0]`, behind any bytes already queued.
- R3: The transmit queue holds 64 bytes (16 words). A write that needs more free space than remains is dropped whole and queues nothing. In that case status bit 3 (transmit overflow) is set at the next clock edge.
- R4: Status bit 0 (transmit drained) is set at the clock edge that ends any cycle in which the transmit queue holds no bytes.
- R5: Status bit 1 (word ready) is set at the edge that ends a cycle in which the receive queue holds four or more bytes. Status bit 2 (byte ready) is set at the edge that ends a cycle in which the receive queue holds one or more bytes.
- R6: A word read (`rx_word_re_i`) with at least four bytes queued returns them on `rx_rdata_o` in the same cycle, oldest byte in bits 7:0 and newest in bits 31:24, and removes them at the edge. A byte read (`rx_byte_re_i`) returns the oldest byte zero-extended and removes it. A word read takes priority over a byte read.
- R7: A read issued with fewer bytes queued than it needs returns zero and leaves the receive queue unchanged.
- R8: Status bits are sticky. Writing a 1 to a bit of `sts_clr_i` with `sts_clr_we_i` high clears that bit at the edge, and the clear wins over a set in that cycle. If the bit's condition still holds, the bit sets again one edge later. An all-ones mask clears every bit.
- R9: While `soft_rst_i` is high, both queues become empty at the edge, and any push or pop in that cycle is discarded.
- R10: While `rst_ni` is low, every status bit is 0, `tx_valid_o` is 0 and `rx_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Flush both queues |
| tx_word_we_i | input | 1 | Queue four bytes from `tx_wdata_i` |
| tx_byte_we_i | input | 1 | Queue the low byte of `tx_wdata_i` |
| tx_wdata_i | input | 32 | Transmit write data |
| tx_byte_o | output | 8 | Oldest transmit byte, for the shift engine |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Shift engine takes `tx_byte_o` |
| rx_byte_i | input | 8 | Received byte from the shift engine |
| rx_valid_i | input | 1 | Push `rx_byte_i` into the receive queue |
| rx_word_re_i | input | 1 | Read and remove four received bytes |
| rx_byte_re_i | input | 1 | Read and remove one received byte |
| rx_rdata_o | output | 32 | Receive read data, valid in the cycle of the read strobe |
| sts_clr_we_i | input | 1 | Apply the clear mask |
| sts_clr_i | input | 4 | Write-one-to-clear mask for the status bits |
| sts_o | output | 4 | Sticky status: 0 drained, 1 word ready, 2 byte ready, 3 overflow |

## Verification
The assertions assume the control inputs are never unknown after reset. They also assume the shift engine does not push a received byte into a full receive queue when the result matters, because that byte is silently lost. The overflow and empty-read properties assume no soft reset is asserted in the same cycle, so both are qualified on `soft_rst_i` being low. The stimulus asserts at most one strobe per direction in any cycle and changes inputs only on falling edges. It fills the transmit queue exactly to 63 bytes before the dropped word, and issues reads against 0, 3 and 5 queued bytes.

// File: rtl/spi_dfifo_pkg.sv
package spi_dfifo_pkg;
  localparam int STS_W        = 4;
  localparam int STS_TX_EMPTY = 0;
  localparam int STS_RX_WORD  = 1;
  localparam int STS_RX_BYTE  = 2;
  localparam int STS_TX_OVF   = 3;
  localparam int WORD_BYTES   = 4;
endpackage

// File: rtl/dfifo_bytes.sv
// Byte queue with multi-byte push and pop. DEPTH must be a power of two.
module dfifo_bytes #(
  parameter int DEPTH      = 64,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES  = 1,
  localparam int PW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int PNW = $clog2(PUSH_LANES + 1),
  localparam int QNW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [PNW-1:0]          push_n_i,
  input  logic [8*PUSH_LANES-1:0] push_data_i,
  input  logic [QNW-1:0]          pop_n_i,
  output logic [8*POP_LANES-1:0]  peek_o,
  output logic [CW-1:0]           count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      wr_q    <= wr_q + PW'(push_n_i);
      rd_q    <= rd_q + PW'(pop_n_i);
      count_q <= count_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < PUSH_LANES; k++) begin
      if (!flush_i && (PNW'(k) < push_n_i))
        mem_q[PW'(wr_q + PW'(k))] <= push_data_i[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < POP_LANES; k++)
      peek_o[8*k +: 8] = (CW'(k) < count_q) ? mem_q[PW'(rd_q + PW'(k))] : 8'h00;
  end

  assign count_o = count_q;

  assert_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_pop_avail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_n_i) <= count_q);
  assert_push_room_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW'(push_n_i) + count_q) <= CW'(DEPTH) + CW'(pop_n_i));
endmodule

// File: rtl/dfifo_sticky.sv
// Sticky status bits; the clear mask wins over a set in the same cycle.
module dfifo_sticky #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q, clr_mask;

  assign clr_mask = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q | set_i) & ~clr_mask;
  end

  assign sts_o = sts_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_mask[b] |=> !sts_o[b]);
    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_o[b] && !clr_mask[b]) |=> sts_o[b]);
    assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[b] && !clr_mask[b]) |=> sts_o[b]);
  end
endmodule

// File: rtl/spi_data_fifo.sv
module spi_data_fifo
  import spi_dfifo_pkg::*;
#(
  parameter int TX_WORDS = 16,
  parameter int RX_WORDS = 16,
  localparam int TX_DEPTH = WORD_BYTES * TX_WORDS,
  localparam int RX_DEPTH = WORD_BYTES * RX_WORDS,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1),
  localparam int LNW = $clog2(WORD_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             tx_word_we_i,
  input  logic             tx_byte_we_i,
  input  logic [31:0]      tx_wdata_i,
  output logic [7:0]       tx_byte_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_valid_i,
  input  logic             rx_word_re_i,
  input  logic             rx_byte_re_i,
  output logic [31:0]      rx_rdata_o,
  input  logic             sts_clr_we_i,
  input  logic [STS_W-1:0] sts_clr_i,
  output logic [STS_W-1:0] sts_o
);
  logic [TCW-1:0]   tx_cnt, tx_free;
  logic [RCW-1:0]   rx_cnt;
  logic [LNW-1:0]   tx_want, tx_push_n, rx_pop_n;
  logic             tx_fit, tx_ovf, tx_pop, rx_push;
  logic [31:0]      rx_peek;
  logic [STS_W-1:0] sts_set;

  // Transmit admission: a write is taken whole or not at all
  assign tx_want   = tx_word_we_i ? LNW'(WORD_BYTES) : (tx_byte_we_i ? LNW'(1) : '0);
  assign tx_free   = TCW'(TX_DEPTH) - tx_cnt;
  assign tx_fit    = TCW'(tx_want) <= tx_free;
  assign tx_push_n = (tx_fit && !soft_rst_i) ? tx_want : '0;
  assign tx_ovf    = !soft_rst_i && (tx_want != '0) && !tx_fit;
  assign tx_valid_o = tx_cnt != '0;
  assign tx_pop    = tx_ready_i && tx_valid_o && !soft_rst_i;

  dfifo_bytes #(
    .DEPTH(TX_DEPTH), .PUSH_LANES(WORD_BYTES), .POP_LANES(1)
  ) tx_q_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (soft_rst_i),
    .push_n_i    (tx_push_n),
    .push_data_i (tx_wdata_i),
    .pop_n_i     (tx_pop),
    .peek_o      (tx_byte_o),
    .count_o     (tx_cnt)
  );

  // Receive side: word read has priority, short reads return zero
  assign rx_push = rx_valid_i && (rx_cnt < RCW'(RX_DEPTH)) && !soft_rst_i;

  always_comb begin
    rx_pop_n   = '0;
    rx_rdata_o = '0;
    if (!soft_rst_i) begin
      if (rx_word_re_i) begin
        if (rx_cnt >= RCW'(WORD_BYTES)) begin
          rx_pop_n   = LNW'(WORD_BYTES);
          rx_rdata_o = rx_peek;
        end
      end else if (rx_byte_re_i && rx_cnt != '0) begin
        rx_pop_n   = LNW'(1);
        rx_rdata_o = {24'h0, rx_peek[7:0]};
      end
    end
  end

  dfifo_bytes #(
    .DEPTH(RX_DEPTH), .PUSH_LANES(1), .POP_LANES(WORD_BYTES)
  ) rx_q_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (soft_rst_i),
    .push_n_i    (rx_push),
    .push_data_i (rx_byte_i),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );

  always_comb begin
    sts_set               = '0;
    sts_set[STS_TX_EMPTY] = tx_cnt == '0;
    sts_set[STS_RX_WORD]  = rx_cnt >= RCW'(WORD_BYTES);
    sts_set[STS_RX_BYTE]  = rx_cnt != '0;
    sts_set[STS_TX_OVF]   = tx_ovf;
  end

  dfifo_sticky #(.W(STS_W)) sts_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (sts_set),
    .clr_we_i (sts_clr_we_i),
    .clr_i    (sts_clr_i),
    .sts_o    (sts_o)
  );

  assert_soft_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_valid_o));
  assert_short_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_word_re_i && rx_cnt < RCW'(WORD_BYTES) && !rx_valid_i && !soft_rst_i)
      |=> $stable(rx_cnt));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_word_we_i && !soft_rst_i && tx_cnt > TCW'(TX_DEPTH - WORD_BYTES)
     && !(sts_clr_we_i && sts_clr_i[STS_TX_OVF])) |=> sts_o[STS_TX_OVF]);
  assert_word_push_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_word_we_i && !soft_rst_i && !tx_pop && tx_cnt <= TCW'(TX_DEPTH - WORD_BYTES))
      |=> tx_cnt == $past(tx_cnt) + TCW'(WORD_BYTES));
endmodule

// File: tb/spi_data_fifo_tb_top.sv
module spi_data_fifo_tb_top;
  localparam logic [3:0] OP_IDLE = 4'd0, OP_TXW = 4'd1, OP_TXB = 4'd2, OP_PULL = 4'd3,
                         OP_RXP  = 4'd4, OP_RDW = 4'd5, OP_RDB = 4'd6, OP_CLR  = 4'd7,
                         OP_CHK  = 4'd8, OP_SOFT = 4'd9;
  localparam int NV = 31;
  // {op, requirement, data, expected}
  localparam logic [71:0] VEC [NV] = '{
    {OP_CLR,  4'd8, 32'h0000000F, 32'h0},        // R8 clear all
    {OP_CHK,  4'd8, 32'h0,        32'h0},        // R8 cleared
    {OP_CHK,  4'd4, 32'h0,        32'h1},        // R4 re-set, queue empty
    {OP_TXW,  4'd1, 32'h44332211, 32'h0},        // R1
    {OP_TXB,  4'd2, 32'hAABBCC55, 32'h0},        // R2 low byte only
    {OP_CLR,  4'd8, 32'h00000001, 32'h0},        // R8
    {OP_CHK,  4'd4, 32'h0,        32'h0},        // R4 stays clear, not empty
    {OP_PULL, 4'd1, 32'h0,        32'h11},       // R1 byte order
    {OP_PULL, 4'd1, 32'h0,        32'h22},
    {OP_PULL, 4'd1, 32'h0,        32'h33},
    {OP_PULL, 4'd1, 32'h0,        32'h44},
    {OP_PULL, 4'd2, 32'h0,        32'h55},       // R2
    {OP_CHK,  4'd4, 32'h0,        32'h0},        // R4 one edge later
    {OP_CHK,  4'd4, 32'h0,        32'h1},        // R4
    {OP_RXP,  4'd5, 32'hA1,       32'h0},
    {OP_RXP,  4'd5, 32'hB2,       32'h0},
    {OP_RXP,  4'd5, 32'hC3,       32'h0},
    {OP_RDW,  4'd7, 32'h0,        32'h0},        // R7 three bytes only
    {OP_RXP,  4'd5, 32'hD4,       32'h0},
    {OP_RXP,  4'd5, 32'hE5,       32'h0},
    {OP_RDW,  4'd6, 32'h0,        32'hD4C3B2A1}, // R6 oldest low
    {OP_RDB,  4'd6, 32'h0,        32'hE5},       // R6
    {OP_RDB,  4'd7, 32'h0,        32'h0},        // R7 empty
    {OP_CHK,  4'd5, 32'h0,        32'h7},        // R5 sticky word/byte
    {OP_CLR,  4'd8, 32'h00000006, 32'h0},
    {OP_CHK,  4'd5, 32'h0,        32'h1},        // R5 no re-set when empty
    {OP_RXP,  4'd5, 32'h5A,       32'h0},
    {OP_CHK,  4'd5, 32'h0,        32'h1},
    {OP_CHK,  4'd5, 32'h0,        32'h5},        // R5 byte ready only
    {OP_RDB,  4'd6, 32'h0,        32'h5A},
    {OP_RDW,  4'd7, 32'h0,        32'h0}         // R7
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0;
  logic        tx_word_we_i = 1'b0, tx_byte_we_i = 1'b0, tx_ready_i = 1'b0;
  logic [31:0] tx_wdata_i = '0;
  logic [7:0]  rx_byte_i = '0, tx_byte_o;
  logic        rx_valid_i = 1'b0, rx_word_re_i = 1'b0, rx_byte_re_i = 1'b0;
  logic        sts_clr_we_i = 1'b0, tx_valid_o;
  logic [3:0]  sts_clr_i = '0, sts_o;
  logic [31:0] rx_rdata_o;
  int n_chk = 0, n_fail = 0;

  always #2ns clk_i = ~clk_i;

  spi_data_fifo dut_i (.*);

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] code, input int req, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk_i);
    tx_word_we_i = 0; tx_byte_we_i = 0; tx_ready_i = 0; rx_valid_i = 0;
    rx_word_re_i = 0; rx_byte_re_i = 0; sts_clr_we_i = 0; soft_rst_i = 0;
    tx_wdata_i = d; rx_byte_i = d[7:0]; sts_clr_i = d[3:0];
    case (code)
      OP_TXW:  tx_word_we_i = 1;
      OP_TXB:  tx_byte_we_i = 1;
      OP_PULL: tx_ready_i = 1;
      OP_RXP:  rx_valid_i = 1;
      OP_RDW:  rx_word_re_i = 1;
      OP_RDB:  rx_byte_re_i = 1;
      OP_CLR:  sts_clr_we_i = 1;
      OP_SOFT: begin soft_rst_i = 1; tx_byte_we_i = 1; rx_valid_i = 1; end
      default: ;
    endcase
    #1ns;
    case (code)
      OP_CHK:  check(sts_o == e[3:0], req, {28'h0, sts_o}, e);
      OP_PULL: check(tx_valid_o && tx_byte_o == e[7:0], req, {23'h0, tx_valid_o, tx_byte_o}, {23'h0, 1'b1, e[7:0]});
      OP_RDW, OP_RDB: check(rx_rdata_o == e, req, rx_rdata_o, e);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R10: actual watchdog timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1ns;
    // R10: reset state
    check(sts_o == 4'h0, 10, {28'h0, sts_o}, 32'h0);
    check(!tx_valid_o, 10, {31'h0, tx_valid_o}, 32'h0);
    check(rx_rdata_o == '0, 10, rx_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1;
    #1ns;
    check(sts_o == 4'h0, 10, {28'h0, sts_o}, 32'h0);

    for (int i = 0; i < NV; i++)
      op(VEC[i][71:68], int'(VEC[i][67:64]), VEC[i][63:32], VEC[i][31:0]);

    // R3: fill to 63 bytes, drop a word, take a byte, drop a byte
    op(OP_CLR, 3, 32'hF, 0);
    for (int w = 0; w < 15; w++)
      op(OP_TXW, 3, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, 0);
    for (int b = 60; b < 63; b++) op(OP_TXB, 3, 32'(b), 0);
    check(sts_o[3] == 1'b0, 3, {28'h0, sts_o}, 32'h1);
    op(OP_TXW, 3, 32'hEEEEEEEE, 0);
    op(OP_TXB, 3, 32'd63, 0);
    check(sts_o[3] == 1'b1, 3, {28'h0, sts_o}, 32'h9);
    op(OP_TXB, 3, 32'h77, 0);
    for (int k = 0; k < 64; k++) op(OP_PULL, 3, 0, 32'(k));
    op(OP_IDLE, 3, 0, 0);
    check(!tx_valid_o, 3, {31'h0, tx_valid_o}, 32'h0);

    // R9: soft reset flushes both queues and discards same-cycle pushes
    op(OP_TXW, 9, 32'h12345678, 0);
    for (int b = 0; b < 4; b++) op(OP_RXP, 9, 32'h30 + 32'(b), 0);
    op(OP_SOFT, 9, 32'h99, 0);
    op(OP_IDLE, 9, 0, 0);
    check(!tx_valid_o, 9, {31'h0, tx_valid_o}, 32'h0);
    op(OP_RDW, 9, 0, 32'h0);
    op(OP_RDB, 9, 0, 32'h0);

    // R8: all-ones clear while conditions hold, then re-set
    op(OP_RXP, 8, 32'h42, 0);
    op(OP_IDLE, 8, 0, 0);
    op(OP_CLR, 8, 32'hF, 0);
    op(OP_CHK, 8, 0, 32'h0);
    op(OP_CHK, 8, 0, 32'h5);
    op(OP_RDB, 6, 0, 32'h42);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule